// File: doc/BRIEF.md
# PATA PIO Cycle Timing Generator

This block turns single host register accesses into parallel ATA programmed-I/O bus cycles. The host presents an address inside the command-block window or the alternate-status/device-control address, together with a direction and write data. The block drives the two chip selects and the three-bit register address. After a one-clock setup it pulses the read or write strobe for a counted number of core clocks, then holds a counted recovery gap with the bus still driven. When recovery ends it returns a one-clock done pulse. For reads, the captured data is returned with that pulse.

Timing comes from four timing registers on a small configuration bus. Each holds one byte per attached device: device 0 in the low byte and device 1 in the high byte. Accesses to the 16-bit data port use the data strobe and recovery pair. Every other taskfile or control access uses the register strobe and recovery pair. The device whose bytes apply is the one selected by the device-select bit of the last write to the device register. After reset, every field holds the slowest-mode values for a 600 ns cycle. No bus cycle starts until the global enable bit is set.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset, the configuration registers read as follows. Control (cfg address 0) reads 0x0000. Each device byte of data strobe (address 1) reads ceil(165/T)-1, and of data recovery (address 2) reads ceil(600/T)-ceil(165/T)-1. Each device byte of register strobe (address 3) reads ceil(290/T)-1, and of register recovery (address 4) reads ceil(600/T)-ceil(290/T)-1. T is the clock period in ns, so at 20 ns the four registers read 0x0808, 0x1414, 0x0E0E and 0x0E0E.
- R2: In each timing register, bits 7:0 belong to device 0 and bits 15:8 to device 1. A configuration write updates only the bytes whose byte enable (cfg_be[0] low byte, cfg_be[1] high byte) is set, and the other byte keeps its value.
- R3: While bit 15 of the control register is clear, host_busy is high and no chip select or strobe asserts, even with a request pending. Setting the bit lets the pending request start.
- R4: Addresses 0x1F0 to 0x1F7 drive ata_cs_n = 2'b10 and ata_da = address bits 2:0. Address 0x3F6 drives ata_cs_n = 2'b01 and ata_da = 6. Any other address produces no bus activity. Its done pulse follows one clock after acceptance, and it returns read data 0.
- R5: The strobe stays low for strobe field + 1 clocks. It is followed by recovery field + 1 clocks with the chip select still asserted and both strobes high.
- R6: An access to 0x1F0 is timed by the data strobe/recovery pair. All other mapped accesses are timed by the register strobe/recovery pair.
- R7: The selected device is bit 4 of the most recent write to 0x1F6 (0 after reset). That write itself is timed with the device selected before it.
- R8: Chip selects, address and, for writes, ata_dd_out with ata_dd_oe high are driven for exactly one clock before the strobe falls. They stay unchanged until recovery ends.
- R9: For a read, ata_dd_in is captured on the clock edge where the read strobe rises, and it is presented on host_rdata with the done pulse.
- R10: host_done is a one-clock pulse in the first clock after recovery, with the chip selects released. host_busy is high from acceptance until then. A request held while host_busy is high is accepted afterwards, never dropped.
- R11: ata_dior_n and ata_diow_n are never low together. A read uses only ata_dior_n and a write uses only ata_diow_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_be | input | 2 | Byte enables (bit 0 = device 0 byte) |
| cfg_rdata | output | 16 | Configuration read data for cfg_addr |
| host_req | input | 1 | Host access request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_busy | output | 1 | Request cannot be accepted this clock |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Read data of the last completed read |
| ata_cs_n | output | 2 | Chip selects, bit 0 command block, bit 1 control block |
| ata_da | output | 3 | Register address on the bus |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Bus write data |
| ata_dd_oe | output | 1 | Bus data output enable |
| ata_dd_in | input | 16 | Bus read data |

## Verification
The assertions check every clock that the strobes never overlap, that no strobe rises without a chip select that was already set one clock earlier, that chip select and address stay put for the whole cycle, and that no cycle starts while the block is disabled. They also check that a single-byte configuration write leaves the other device's data strobe byte alone. The measured strobe and recovery lengths per device and per access class only show up in the bench scenarios. So do the device switch taking effect one access late, the read data latched at the strobe edge, and the reset register values. There a bus monitor measures each cycle and compares it against a queue of expectations computed from a model of the registers.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
    localparam int unsigned FIELD_W   = 8;
    localparam int unsigned NDEV      = 2;
    localparam int unsigned CFG_AW    = 3;
    localparam int unsigned CFG_DW    = FIELD_W * NDEV;
    localparam int unsigned EN_BIT    = 15;
    localparam int unsigned DEV_BIT   = 4;
    localparam int unsigned REG_IDX_W = 3;
    localparam logic [REG_IDX_W-1:0] DEVREG_IDX = 3'd6;

    localparam int unsigned MODE0_CYCLE_NS = 600;
    localparam int unsigned MODE0_DATA_ACT = 165;
    localparam int unsigned MODE0_REG_ACT  = 290;

    typedef enum logic [CFG_AW-1:0] {
        CFG_CTRL = 3'd0,
        CFG_DSTB = 3'd1,
        CFG_DREC = 3'd2,
        CFG_RSTB = 3'd3,
        CFG_RREC = 3'd4
    } cfg_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } cyc_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] stb;
        logic [FIELD_W-1:0] rec;
    } pio_timing_t;

    typedef struct packed {
        logic                 hit;
        logic [1:0]           cs_n;
        logic [REG_IDX_W-1:0] da;
        logic                 data_port;
        logic                 dev_reg;
    } pio_target_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic [FIELD_W-1:0] stb_field(input int unsigned act_ns, input int unsigned clk_ns);
        return FIELD_W'(ceil_div(act_ns, clk_ns) - 1);
    endfunction

    function automatic logic [FIELD_W-1:0] rec_field(input int unsigned cyc_ns, input int unsigned act_ns,
                                                     input int unsigned clk_ns);
        return FIELD_W'(ceil_div(cyc_ns, clk_ns) - ceil_div(act_ns, clk_ns) - 1);
    endfunction
endpackage

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [CFG_DW-1:0]       cfg_wdata,
    input  logic [NDEV-1:0]         cfg_be,
    output logic [CFG_DW-1:0]       cfg_rdata,
    output logic                    bus_en,
    output pio_timing_t [NDEV-1:0]  data_tim,
    output pio_timing_t [NDEV-1:0]  reg_tim
);
    localparam logic [FIELD_W-1:0] RST_DSTB = stb_field(MODE0_DATA_ACT, CLK_NS);
    localparam logic [FIELD_W-1:0] RST_DREC = rec_field(MODE0_CYCLE_NS, MODE0_DATA_ACT, CLK_NS);
    localparam logic [FIELD_W-1:0] RST_RSTB = stb_field(MODE0_REG_ACT, CLK_NS);
    localparam logic [FIELD_W-1:0] RST_RREC = rec_field(MODE0_CYCLE_NS, MODE0_REG_ACT, CLK_NS);

    logic [NDEV-1:0][FIELD_W-1:0] dstb_q, drec_q, rstb_q, rrec_q;
    logic                         en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dstb_q <= {NDEV{RST_DSTB}};
            drec_q <= {NDEV{RST_DREC}};
            rstb_q <= {NDEV{RST_RSTB}};
            rrec_q <= {NDEV{RST_RREC}};
            en_q   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_CTRL && cfg_be[NDEV-1])
                en_q <= cfg_wdata[EN_BIT];
            for (int d = 0; d < NDEV; d++) begin
                if (cfg_be[d]) begin
                    if (cfg_addr == CFG_DSTB) dstb_q[d] <= cfg_wdata[d*FIELD_W +: FIELD_W];
                    if (cfg_addr == CFG_DREC) drec_q[d] <= cfg_wdata[d*FIELD_W +: FIELD_W];
                    if (cfg_addr == CFG_RSTB) rstb_q[d] <= cfg_wdata[d*FIELD_W +: FIELD_W];
                    if (cfg_addr == CFG_RREC) rrec_q[d] <= cfg_wdata[d*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CFG_CTRL: cfg_rdata[EN_BIT] = en_q;
            CFG_DSTB: cfg_rdata = dstb_q;
            CFG_DREC: cfg_rdata = drec_q;
            CFG_RSTB: cfg_rdata = rstb_q;
            CFG_RREC: cfg_rdata = rrec_q;
            default:  cfg_rdata = '0;
        endcase
    end

    assign bus_en = en_q;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        assign data_tim[d] = {dstb_q[d], drec_q[d]};
        assign reg_tim[d]  = {rstb_q[d], rrec_q[d]};
    end
endmodule

// File: rtl/pio_addr_decode.sv
`timescale 1ns/1ps
module pio_addr_decode
    import pio_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 10,
    parameter logic [ADDR_W-1:0]  CMD_BASE = 10'h1F0,
    parameter logic [ADDR_W-1:0]  CTL_ADDR = 10'h3F6
) (
    input  logic [ADDR_W-1:0] addr,
    output pio_target_t       tgt
);
    always_comb begin
        tgt      = '0;
        tgt.cs_n = 2'b11;
        if (addr[ADDR_W-1:REG_IDX_W] == CMD_BASE[ADDR_W-1:REG_IDX_W]) begin
            tgt.hit       = 1'b1;
            tgt.cs_n      = 2'b10;
            tgt.da        = addr[REG_IDX_W-1:0];
            tgt.data_port = (addr[REG_IDX_W-1:0] == '0);
            tgt.dev_reg   = (addr[REG_IDX_W-1:0] == DEVREG_IDX);
        end else if (addr == CTL_ADDR) begin
            tgt.hit  = 1'b1;
            tgt.cs_n = 2'b01;
            tgt.da   = CTL_ADDR[REG_IDX_W-1:0];
        end
    end
endmodule

// File: rtl/pio_cycle_fsm.sv
`timescale 1ns/1ps
module pio_cycle_fsm
    import pio_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 hit,
    input  logic [1:0]           tgt_cs_n,
    input  logic [REG_IDX_W-1:0] tgt_da,
    input  pio_timing_t          tim,
    input  logic                 we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    dd_in,
    output logic                 busy,
    output logic [1:0]           cs_n,
    output logic [REG_IDX_W-1:0] da,
    output logic                 dior_n,
    output logic                 diow_n,
    output logic [DATA_W-1:0]    dd_out,
    output logic                 dd_oe,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done
);
    cyc_state_e           st_q;
    logic [FIELD_W-1:0]   cnt_q, rec_q;
    logic [1:0]           cs_q;
    logic [REG_IDX_W-1:0] da_q;
    logic                 we_q, done_q;
    logic [DATA_W-1:0]    wdata_q, rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            rec_q   <= '0;
            cs_q    <= 2'b11;
            da_q    <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (hit) begin
                            st_q    <= ST_SETUP;
                            cs_q    <= tgt_cs_n;
                            da_q    <= tgt_da;
                            we_q    <= we;
                            wdata_q <= wdata;
                            cnt_q   <= tim.stb;
                            rec_q   <= tim.rec;
                        end else begin
                            done_q  <= 1'b1;
                            rdata_q <= '0;
                        end
                    end
                end
                ST_SETUP: st_q <= ST_STROBE;
                ST_STROBE: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_RECOVER;
                        cnt_q <= rec_q;
                        if (!we_q) rdata_q <= dd_in;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt_q == '0) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != ST_IDLE);
    assign cs_n   = (st_q == ST_IDLE) ? 2'b11 : cs_q;
    assign da     = da_q;
    assign dior_n = !(st_q == ST_STROBE && !we_q);
    assign diow_n = !(st_q == ST_STROBE && we_q);
    assign dd_oe  = we_q && (st_q != ST_IDLE);
    assign dd_out = wdata_q;
    assign rdata  = rdata_q;
    assign done   = done_q;
endmodule

// File: rtl/pio_cycle_engine.sv
`timescale 1ns/1ps
module pio_cycle_engine
    import pio_pkg::*;
#(
    parameter int unsigned       CLK_NS   = 20,
    parameter int unsigned       ADDR_W   = 10,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_BASE = 10'h1F0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 10'h3F6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic [1:0]        cfg_be,
    output logic [15:0]       cfg_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [1:0]        ata_cs_n,
    output logic [2:0]        ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in
);
    logic                   bus_en, fsm_busy, accept, dev_q;
    pio_timing_t [NDEV-1:0] data_tim, reg_tim;
    pio_timing_t            tim_sel;
    pio_target_t            tgt;

    pio_timing_regs #(.CLK_NS(CLK_NS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_be   (cfg_be),
        .cfg_rdata(cfg_rdata),
        .bus_en   (bus_en),
        .data_tim (data_tim),
        .reg_tim  (reg_tim)
    );

    pio_addr_decode #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CTL_ADDR(CTL_ADDR)) u_dec (
        .addr(host_addr),
        .tgt (tgt)
    );

    assign host_busy = fsm_busy | ~bus_en;
    assign accept    = host_req & ~host_busy;
    assign tim_sel   = tgt.data_port ? data_tim[dev_q] : reg_tim[dev_q];

    always_ff @(posedge clk) begin
        if (rst)
            dev_q <= 1'b0;
        else if (accept && host_we && tgt.dev_reg)
            dev_q <= host_wdata[DEV_BIT];
    end

    pio_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .hit     (tgt.hit),
        .tgt_cs_n(tgt.cs_n),
        .tgt_da  (tgt.da),
        .tim     (tim_sel),
        .we      (host_we),
        .wdata   (host_wdata),
        .dd_in   (ata_dd_in),
        .busy    (fsm_busy),
        .cs_n    (ata_cs_n),
        .da      (ata_da),
        .dior_n  (ata_dior_n),
        .diow_n  (ata_diow_n),
        .dd_out  (ata_dd_out),
        .dd_oe   (ata_dd_oe),
        .rdata   (host_rdata),
        .done    (host_done)
    );
endmodule

// File: rtl/pio_cycle_engine_chk.sv
`timescale 1ns/1ps
module pio_cycle_engine_chk
    import pio_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_en,
    input pio_timing_t [NDEV-1:0] data_tim,
    input logic                   cfg_we,
    input logic [2:0]             cfg_addr,
    input logic [1:0]             cfg_be,
    input logic [1:0]             ata_cs_n,
    input logic [2:0]             ata_da,
    input logic                   ata_dior_n,
    input logic                   ata_diow_n,
    input logic                   host_busy,
    input logic                   host_done
);
    logic strb;
    assign strb = !ata_dior_n || !ata_diow_n;

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));

    p_setup_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(strb) |-> (ata_cs_n != 2'b11) && ($past(ata_cs_n) == ata_cs_n) && ($past(ata_da) == ata_da));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ata_cs_n != 2'b11 && $past(ata_cs_n) != 2'b11) |-> $stable(ata_cs_n) && $stable(ata_da));

    p_busy_in_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        strb |-> host_busy);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        host_done |-> ata_cs_n == 2'b11 && !strb);

    p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_en && ata_cs_n == 2'b11) |=> ata_cs_n == 2'b11);

    p_keep_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_DSTB && cfg_be == 2'b01) |=> $stable(data_tim[1].stb));
endmodule

bind pio_cycle_engine pio_cycle_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .data_tim  (data_tim),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .ata_cs_n  (ata_cs_n),
    .ata_da    (ata_da),
    .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n),
    .host_busy (host_busy),
    .host_done (host_done)
);

// File: tb/pio_cycle_engine_test.sv
`timescale 1ns/1ps
module pio_cycle_engine_test;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_rdata;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [15:0] host_rdata;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;
    logic        ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [15:0] ata_dd_out;
    logic [15:0] ata_dd_in = '0;

    int checks = 0, errors = 0;

    typedef struct {
        logic [1:0]  cs;
        logic [2:0]  da;
        logic        we;
        logic [15:0] wd;
        int          stb;
        int          rec;
        string       tag;
    } exp_t;
    exp_t expq[$];

    logic [7:0] m_dstb[2], m_drec[2], m_rstb[2], m_rrec[2];
    logic       m_dev;

    always #10 clk = ~clk;

    pio_cycle_engine uut (.*);

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // bus monitor: measures every cycle and compares against the queue
    int   s_cnt, r_cnt, pre_cnt;
    logic in_cyc = 1'b0, hold_bad, cur_we, oe_bad;
    logic [1:0]  cur_cs;
    logic [2:0]  cur_da;
    logic [15:0] cur_wd;
    always @(negedge clk) begin
        if (!rst) begin
            if (ata_cs_n != 2'b11) begin
                if (!in_cyc) begin
                    in_cyc = 1'b1; cur_cs = ata_cs_n; cur_da = ata_da;
                    s_cnt = 0; r_cnt = 0; pre_cnt = 0; hold_bad = 1'b0;
                    cur_we = 1'b0; oe_bad = 1'b0; cur_wd = '0;
                end
                if (ata_cs_n != cur_cs || ata_da != cur_da) hold_bad = 1'b1;
                if (!ata_dior_n || !ata_diow_n) begin
                    s_cnt++;
                    if (!ata_diow_n) begin
                        cur_we = 1'b1; cur_wd = ata_dd_out;
                        if (!ata_dd_oe) oe_bad = 1'b1;
                    end
                end else if (s_cnt == 0) pre_cnt++;
                else r_cnt++;
            end else if (in_cyc) begin
                exp_t e;
                in_cyc = 1'b0;
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "unexpected bus cycle", 1, 0);
                end else begin
                    e = expq.pop_front();
                    check(cur_cs == e.cs, "R4", {e.tag, " chip select"}, cur_cs, e.cs);
                    check(cur_da == e.da, "R4", {e.tag, " address"}, cur_da, e.da);
                    check(cur_we == e.we, "R11", {e.tag, " strobe kind"}, cur_we, e.we);
                    check(s_cnt == e.stb, "R5", {e.tag, " strobe clocks"}, s_cnt, e.stb);
                    check(r_cnt == e.rec, "R5", {e.tag, " recovery clocks"}, r_cnt, e.rec);
                    check(pre_cnt == 1, "R8", {e.tag, " setup clocks"}, pre_cnt, 1);
                    check(!hold_bad, "R8", {e.tag, " held address"}, hold_bad, 0);
                    if (e.we) begin
                        check(cur_wd == e.wd && !oe_bad, "R8", {e.tag, " write data"}, cur_wd, e.wd);
                    end
                end
            end
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (be[k]) begin
                case (a)
                    3'd1: m_dstb[k] = d[k*8 +: 8];
                    3'd2: m_drec[k] = d[k*8 +: 8];
                    3'd3: m_rstb[k] = d[k*8 +: 8];
                    3'd4: m_rrec[k] = d[k*8 +: 8];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic cfg_check(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, req, "register readback", cfg_rdata, exp);
    endtask

    task automatic access(input logic we, input logic [9:0] addr, input logic [15:0] wd,
                          input logic [15:0] ddval, input string tag);
        exp_t e;
        bit   mapped, is_data;
        mapped  = (addr[9:3] == 7'h3E) || (addr == 10'h3F6);
        is_data = (addr == 10'h1F0);
        if (mapped) begin
            e.cs  = (addr == 10'h3F6) ? 2'b01 : 2'b10;
            e.da  = addr[2:0];
            e.we  = we;
            e.wd  = wd;
            e.stb = (is_data ? m_dstb[m_dev] : m_rstb[m_dev]) + 1;
            e.rec = (is_data ? m_drec[m_dev] : m_rrec[m_dev]) + 1;
            e.tag = tag;
            expq.push_back(e);
            if (we && addr == 10'h1F6) m_dev = wd[4];
        end
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd; ata_dd_in = ddval;
        while (host_busy) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        if (mapped) begin
            check(host_busy && !host_done, "R10", {tag, " busy after accept"}, host_busy, 1);
        end else begin
            check(host_done && ata_cs_n == 2'b11, "R4", {tag, " unmapped done next clock"}, host_done, 1);
        end
        while (!host_done) @(negedge clk);
        if (!we) begin
            check(host_rdata == (mapped ? ddval : 16'h0), "R9", {tag, " read data"},
                  host_rdata, mapped ? ddval : 16'h0);
        end
        @(negedge clk);
        check(!host_done, "R10", {tag, " done is one clock"}, host_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog: actual=hung expected=complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_dstb[k] = 8'(cdiv(165, T) - 1);
            m_drec[k] = 8'(cdiv(600, T) - cdiv(165, T) - 1);
            m_rstb[k] = 8'(cdiv(290, T) - 1);
            m_rrec[k] = 8'(cdiv(600, T) - cdiv(290, T) - 1);
        end
        m_dev = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ata_cs_n == 2'b11 && ata_dior_n && ata_diow_n, "R1", "bus idle after reset", ata_cs_n, 3);
        check(!host_done, "R1", "no done after reset", host_done, 0);

        // R1 reset register contents
        cfg_check(3'd0, 16'h0000, "R1");
        cfg_check(3'd1, {m_dstb[1], m_dstb[0]}, "R1");
        cfg_check(3'd2, {m_drec[1], m_drec[0]}, "R1");
        cfg_check(3'd3, {m_rstb[1], m_rstb[0]}, "R1");
        cfg_check(3'd4, {m_rrec[1], m_rrec[0]}, "R1");
        cfg_check(3'd1, 16'h0808, "R1");

        // R3 disabled: pending request must not start
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 10'h1F7;
        repeat (10) @(negedge clk);
        check(host_busy && ata_cs_n == 2'b11, "R3", "stalled while disabled", ata_cs_n, 3);
        host_req = 1'b0;
        cfg_write(3'd0, 16'h8000, 2'b11);
        cfg_check(3'd0, 16'h8000, "R3");

        // R5 R6 R9 R4 R8 R11 with reset timing, device 0
        access(1'b0, 10'h1F0, 16'h0000, 16'hA5C3, "R6 data read dev0");
        access(1'b1, 10'h1F2, 16'h0055, 16'h0000, "R6 reg write");
        access(1'b0, 10'h3F6, 16'h0000, 16'h0050, "R4 control read");
        access(1'b1, 10'h1F1, 16'h1234, 16'h0000, "R8 feature write");
        access(1'b0, 10'h200, 16'h0000, 16'hFFFF, "R4 unmapped read");

        // R2 byte-enable writes per device
        cfg_write(3'd1, 16'h03FF, 2'b10);
        cfg_check(3'd1, {m_dstb[1], m_dstb[0]}, "R2");
        cfg_write(3'd3, 16'h05AA, 2'b10);
        cfg_check(3'd3, {m_rstb[1], m_rstb[0]}, "R2");
        cfg_write(3'd2, 16'hEE02, 2'b01);
        cfg_check(3'd2, {m_drec[1], m_drec[0]}, "R2");

        // R7 device switching
        access(1'b0, 10'h1F0, 16'h0000, 16'h7E81, "R7 data read dev0");
        access(1'b1, 10'h1F6, 16'h00F0, 16'h0000, "R7 select dev1 uses dev0");
        access(1'b0, 10'h1F7, 16'h0000, 16'h0058, "R7 status read dev1");
        access(1'b0, 10'h1F0, 16'h0000, 16'hC001, "R7 data read dev1");
        access(1'b1, 10'h1F0, 16'hBEEF, 16'h0000, "R11 data write dev1");
        access(1'b1, 10'h1F6, 16'h00E0, 16'h0000, "R7 select dev0 uses dev1");
        access(1'b0, 10'h1F5, 16'h0000, 16'h0033, "R7 reg read dev0");

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R10", "all expected cycles seen", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule